// File: doc/BRIEF.md
# Debug Read Acknowledge Controller

This block is the command-level controller on the target side of a single-wire background debug link. A serial receiver that has already done the bit-level work hands it bytes one at a time. The block collects an opcode byte and then a two-byte memory address. For the byte-read opcode it requests one bus cycle. That cycle may be an idle slot or one taken from the CPU. On the grant it latches the full 16-bit word that the bus returns.

Once the word is captured, the block acknowledges on the open-drain debug pin. It pulls the pin low for a fixed number of debug-clock ticks, drives it high for one tick to speed up the rising edge, and then releases it. After that it offers the word to the serial transmitter. The word is always returned whole. The host picks the byte it wants from the low address bit. A low-power indication (wait or stop) cancels a command that has not yet reached its bus cycle, and no acknowledge is sent for it.

Top module: `dbg_ack_ctrl`

## Requirements
- R1: After reset, `pin_oe_o`, `pin_o`, `bus_req_o` and `tx_valid_o` are all 0.
- R2: `bus_req_o` stays 0 until the opcode byte 8'hE0 and two address bytes (high byte first) have all been received. It then rises and `bus_addr_o` equals {high, low}.
- R3: A first byte other than 8'hE0 causes no bus request and no acknowledge. The next byte is taken as a new opcode.
- R4: `bus_req_o` is held until the first cycle with `bus_gnt_i` high. `bus_rdata_i` from that cycle is the word later offered.
- R5: In the cycle after the grant, `pin_oe_o`=1 and `pin_o`=0. The pin stays low while exactly 16 `dbg_tick_i` pulses are consumed.
- R6: After the low phase, the pin is driven high (`pin_o`=1, `pin_oe_o`=1) for exactly one tick and is then released (`pin_oe_o`=0, `pin_o`=0).
- R7: `tx_valid_o` is 0 while a command is pending or the acknowledge is in progress. It is 1 once the pin is released, and `tx_word_o` then carries all 16 bits of the read word, whatever the parity of the address.
- R8: A `tx_done_i` pulse clears `tx_valid_o` on the next cycle.
- R9: `lowpwr_i` while the bus request is pending drops the request on the next cycle, and no acknowledge and no word follow. If `lowpwr_i` and `bus_gnt_i` coincide, the cancel wins.
- R10: Bytes received while a command is pending or acknowledging are ignored. They never start a later bus request.
- R11: `lowpwr_i` during a partly received frame discards the bytes already collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| dbg_tick_i | input | 1 | One-cycle debug-clock tick enable |
| lowpwr_i | input | 1 | CPU entering wait or stop |
| bus_req_o | output | 1 | Bus cycle request |
| bus_addr_o | output | 16 | Read address |
| bus_gnt_i | input | 1 | Bus cycle granted, read data valid |
| bus_rdata_i | input | 16 | Read data word |
| pin_o | output | 1 | Debug pin drive value |
| pin_oe_o | output | 1 | Debug pin output enable (0 = high impedance) |
| tx_valid_o | output | 1 | Word ready for the transmitter |
| tx_word_o | output | 16 | Word to transmit |
| tx_done_i | input | 1 | Transmitter finished sending all 16 bits |

## Verification
The grant and the low-power cancel can land in the same cycle. The bench raises `bus_gnt_i` and `lowpwr_i` together on one cycle while a request is pending, with a recognisable data word on `bus_rdata_i`. The cancel must win: the request drops, the pin is never enabled during the following window, and `tx_valid_o` stays 0, so the offered data word never appears.

// File: rtl/dbg_ack_pkg.sv
package dbg_ack_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUS,
    ST_ACK
  } ctl_state_e;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_LOW,
    PH_SPEED
  } ack_phase_e;
endpackage

// File: rtl/dbg_frame_rx.sv
module dbg_frame_rx
  import dbg_ack_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter logic [7:0]  OPC_RD = 8'hE0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              abort_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              frame_valid_o,
  output logic [ADDR_W-1:0] frame_addr_o
);
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
      fv_q   <= 1'b0;
    end else begin
      fv_q <= 1'b0;
      if (abort_i || !accept_i) begin
        cnt_q <= '0;
      end else if (byte_valid_i) begin
        if (cnt_q == '0) begin
          // unknown opcodes are dropped here, next byte is a new opcode
          if (byte_i == OPC_RD) cnt_q <= CNT_W'(1);
        end else begin
          addr_q <= {addr_q[ADDR_W-BYTE_W-1:0], byte_i};
          if (cnt_q == CNT_W'(ADDR_BYTES)) begin
            cnt_q <= '0;
            fv_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign frame_valid_o = fv_q;
  assign frame_addr_o  = addr_q;

  p_frame_after_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> $past(byte_valid_i && accept_i && !abort_i));
endmodule

// File: rtl/dbg_ack_pulse.sv
module dbg_ack_pulse
  import dbg_ack_pkg::*;
#(
  parameter int LOW_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (LOW_TICKS > 1) ? $clog2(LOW_TICKS) : 1;

  ack_phase_e       ph_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_OFF;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_OFF: if (start_i) begin
          ph_q  <= PH_LOW;
          cnt_q <= '0;
        end
        PH_LOW: if (tick_i) begin
          if (cnt_q == CNT_W'(LOW_TICKS - 1)) ph_q <= PH_SPEED;
          else cnt_q <= cnt_q + CNT_W'(1);
        end
        PH_SPEED: if (tick_i) ph_q <= PH_OFF;
        default: ph_q <= PH_OFF;
      endcase
    end
  end

  assign pin_oe_o = (ph_q != PH_OFF);
  assign pin_o    = (ph_q == PH_SPEED);
  assign busy_o   = pin_oe_o;
  assign done_o   = (ph_q == PH_SPEED) && tick_i;

  p_speedup_one_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o && pin_o && tick_i) |=> !pin_oe_o);
  p_low_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o && !pin_o && !tick_i) |=> (pin_oe_o && !pin_o));
endmodule

// File: rtl/dbg_word_buf.sv
module dbg_word_buf #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         clr_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      word_o  <= data_i;
      valid_o <= 1'b1;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

  p_clear_on_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i) |=> !valid_o);
endmodule

// File: rtl/dbg_ack_ctrl.sv
module dbg_ack_ctrl
  import dbg_ack_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         DATA_W    = 16,
  parameter int         LOW_TICKS = 16,
  parameter logic [7:0] OPC_RD    = 8'hE0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              dbg_tick_i,
  input  logic              lowpwr_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_word_o,
  input  logic              tx_done_i
);
  ctl_state_e st_q, st_d;
  logic       frame_valid, accept, take, ack_done, ack_busy, word_valid;

  assign accept = (st_q == ST_IDLE) && !frame_valid;
  // cancel has priority over a grant in the same cycle
  assign take   = (st_q == ST_BUS) && bus_gnt_i && !lowpwr_i;

  dbg_frame_rx #(.ADDR_W(ADDR_W), .OPC_RD(OPC_RD)) u_rx (
    .clk_i, .rst_ni,
    .accept_i     (accept),
    .abort_i      (lowpwr_i),
    .byte_valid_i (rx_valid_i),
    .byte_i       (rx_byte_i),
    .frame_valid_o(frame_valid),
    .frame_addr_o (bus_addr_o)
  );

  dbg_ack_pulse #(.LOW_TICKS(LOW_TICKS)) u_pulse (
    .clk_i, .rst_ni,
    .start_i (take),
    .tick_i  (dbg_tick_i),
    .pin_o   (pin_o),
    .pin_oe_o(pin_oe_o),
    .busy_o  (ack_busy),
    .done_o  (ack_done)
  );

  dbg_word_buf #(.W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .load_i (take),
    .data_i (bus_rdata_i),
    .clr_i  (tx_done_i),
    .word_o (tx_word_o),
    .valid_o(word_valid)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (frame_valid && !lowpwr_i) st_d = ST_BUS;
      ST_BUS:  if (lowpwr_i) st_d = ST_IDLE;
               else if (bus_gnt_i) st_d = ST_ACK;
      ST_ACK:  if (ack_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign bus_req_o  = (st_q == ST_BUS);
  assign tx_valid_o = word_valid && (st_q == ST_IDLE);

  p_cancel_drops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && lowpwr_i) |=> (!bus_req_o && !pin_oe_o));
  p_grant_starts_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && !lowpwr_i) |=> (pin_oe_o && !pin_o));
  p_no_req_during_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> !bus_req_o);
  p_tx_quiet_during_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (!pin_oe_o && !ack_busy));
endmodule

// File: tb/dbg_ack_ctrl_bench.sv
module dbg_ack_ctrl_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        rx_valid = 0, dbg_tick = 0, lowpwr = 0, bus_gnt = 0, tx_done = 0;
  logic [7:0]  rx_byte = 0;
  logic [15:0] bus_rdata = 0;
  logic        bus_req, pin, pin_oe, tx_valid;
  logic [15:0] bus_addr, tx_word;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dbg_ack_ctrl u_dbg_ack_ctrl (
    .clk_i(clk), .rst_ni, .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .dbg_tick_i(dbg_tick), .lowpwr_i(lowpwr), .bus_req_o(bus_req),
    .bus_addr_o(bus_addr), .bus_gnt_i(bus_gnt), .bus_rdata_i(bus_rdata),
    .pin_o(pin), .pin_oe_o(pin_oe), .tx_valid_o(tx_valid),
    .tx_word_o(tx_word), .tx_done_i(tx_done)
  );

  // debug tick: one cycle in four, changed just after the rising edge
  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #2;
      dbg_tick = (div == 0);
      div = (div + 1) % 4;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic wait_req(output bit seen);
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (bus_req) seen = 1; else @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!pin_oe && !pin && !bus_req && !tx_valid, "R1",
        {pin_oe, pin, bus_req, tx_valid}, 0);
  endtask

  task automatic t_read(input logic [15:0] addr, input logic [15:0] data, input int hold);
    bit seen; int lo = 0, sp = 0, txbad = 0;
    send_byte(8'hE0); send_byte(addr[15:8]);
    repeat (3) @(negedge clk);
    chk(!bus_req, "R2 early req", bus_req, 0);
    send_byte(addr[7:0]);
    wait_req(seen);
    chk(seen, "R2 req", seen, 1);
    chk(bus_addr == addr, "R2 addr", bus_addr, addr);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(bus_req && !pin_oe, "R4 hold", bus_req, 1);
    end
    bus_gnt = 1; bus_rdata = data;
    @(negedge clk); bus_gnt = 0; bus_rdata = 16'h0;
    chk(pin_oe && !pin, "R5 start", {pin_oe, pin}, 2);
    chk(!bus_req, "R4 drop", bus_req, 0);
    for (int i = 0; i < 300 && pin_oe; i++) begin
      if (!pin && dbg_tick) lo++;
      if (pin && dbg_tick) sp++;
      if (tx_valid) txbad++;
      @(negedge clk);
    end
    chk(lo == 16, "R5 low ticks", lo, 16);
    chk(sp == 1, "R6 speedup ticks", sp, 1);
    chk(!pin_oe && !pin, "R6 release", {pin_oe, pin}, 0);
    chk(txbad == 0, "R7 early tx", txbad, 0);
    chk(tx_valid && tx_word == data, "R7 word", tx_word, data);
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    chk(!tx_valid, "R8 clear", tx_valid, 0);
  endtask

  task automatic t_bad_opcode;
    int bad = 0;
    send_byte(8'h55); send_byte(8'h12); send_byte(8'h34);
    repeat (10) begin @(negedge clk); if (bus_req || pin_oe) bad++; end
    chk(bad == 0, "R3 unknown opcode", bad, 0);
  endtask

  task automatic t_cancel(input bit with_gnt);
    bit seen; int bad = 0;
    send_byte(8'hE0); send_byte(8'h20); send_byte(8'h04);
    wait_req(seen);
    chk(seen, "R9 req", seen, 1);
    repeat (2) @(negedge clk);
    lowpwr = 1; bus_gnt = with_gnt; bus_rdata = 16'hDEAD;
    @(negedge clk); lowpwr = 0; bus_gnt = 0; bus_rdata = 0;
    chk(!bus_req, "R9 req drop", bus_req, 0);
    repeat (80) begin @(negedge clk); if (pin_oe || tx_valid || bus_req) bad++; end
    chk(bad == 0, with_gnt ? "R9 cancel beats grant" : "R9 no ack", bad, 0);
  endtask

  task automatic t_busy_ignore;
    bit seen; int bad = 0;
    send_byte(8'hE0); send_byte(8'h00); send_byte(8'h08);
    wait_req(seen);
    send_byte(8'hE0);   // while pending
    bus_gnt = 1; bus_rdata = 16'h1357;
    @(negedge clk); bus_gnt = 0;
    send_byte(8'h00); send_byte(8'h30);   // while acknowledging
    send_byte(8'hE0); send_byte(8'h00); send_byte(8'h40);
    for (int i = 0; i < 300 && pin_oe; i++) @(negedge clk);
    repeat (15) begin @(negedge clk); if (bus_req) bad++; end
    chk(bad == 0, "R10 ignored while busy", bad, 0);
    chk(tx_valid && tx_word == 16'h1357, "R10 word kept", tx_word, 16'h1357);
    tx_done = 1; @(negedge clk); tx_done = 0;
  endtask

  task automatic t_partial_abort;
    int bad = 0;
    send_byte(8'hE0); send_byte(8'h12);
    @(negedge clk); lowpwr = 1; @(negedge clk); lowpwr = 0;
    send_byte(8'h34);
    repeat (10) begin @(negedge clk); if (bus_req) bad++; end
    chk(bad == 0, "R11 partial frame dropped", bad, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    t_reset();
    t_read(16'h1000, 16'hA5C3, 0);
    t_read(16'h2001, 16'hBEEF, 3);
    t_bad_opcode();
    t_read(16'hFFFF, 16'h0001, 1);
    t_cancel(0);
    t_cancel(1);
    t_busy_ignore();
    t_partial_abort();
    t_read(16'h0002, 16'h8000, 2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule